// File: doc/BRIEF.md
# Pin-Level EPROM Emulator

A synthesizable stand-in for a 2K x 8 ultraviolet-erasable, one-time-writable memory, meant to sit inside a larger FPGA test rig in place of the real part. Every clock cycle it samples three control levels: the combined enable/program pin, the output-enable pin and a flag telling whether the high programming supply is present. From these it decodes the operating mode. Reads return the stored byte on a registered output with a separate drive-enable that the surrounding logic uses to build a tri-state or wired-OR bus.

Programming works as on the real part. With the high supply present and output enable held high, the enable pin is raised for a pulse and then dropped. When it drops, the addressed byte becomes the old contents ANDed with the input byte, so a program pulse can only clear bits. The pulse length is counted in clock cycles and compared against two limits set by parameters. A pulse outside the limits sets a sticky error flag, and the write still takes place. An erase input returns every location to all ones.

Top module: `eprom_emu`

## Requirements
- R1: After reset the drive-enable is low, the error flag is low and every location reads 8'hFF. Reset is synchronous and active high.
- R2: With the enable pin low, output enable low and the high supply absent (read), `q_en` is high one clock later and `q` carries the byte stored at `addr`.
- R3: `q_en` is high only in the cycle after one in which both the enable pin and output enable were low. Whenever `q_en` is low, `q` is 8'h00.
- R4: With the enable pin low and output enable low while the high supply is present (verify), the stored byte is driven exactly as in a read.
- R5: A program pulse starts when the enable pin rises while `vpp_hi` and `oe_n` are both high, coming from a cycle with the enable pin low in that same condition. The write lands in the first cycle the enable pin is seen low again, and the byte at `addr` becomes old AND `d`.
- R6: A 1 written over a 0 has no effect. Pulsing a location again with the same data leaves it unchanged.
- R7: Inhibit (enable pin low, `oe_n` high, `vpp_hi` high), deselect and standby leave `q_en` low and the array unchanged. A pulse is dropped without a write if `vpp_hi` falls or `oe_n` falls before the enable pin returns low.
- R8: A pulse's width is the number of cycles the enable pin was sampled high. If the width is below PULSE_MIN or above PULSE_MAX, `width_err` goes high one cycle after the write and stays high until reset. The write is still applied.
- R9: A cycle with `erase` high returns every location to 8'hFF from the next cycle on. It leaves `width_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_pgm_n | input | 1 | Enable pin, active low; a high pulse programs |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | High programming supply present |
| erase | input | 1 | Return all locations to all ones |
| addr | input | 11 | Byte address |
| d | input | 8 | Data to program |
| q | output | 8 | Read data, 8'h00 when not driven |
| q_en | output | 1 | Output drive enable |
| width_err | output | 1 | Sticky out-of-range pulse flag |

## Verification
Programming is tried with data patterns that only clear bits, with patterns that try to set bits again, and with repeated identical pulses. Together these separate AND behaviour from a plain overwrite. Pulse widths at 44, 45, 55 and 56 cycles each sit on one side of a limit, so an off-by-one in either comparison is caught. Inhibit, deselect, standby and aborted pulses are followed by verify reads, which show that nothing was written. Reads in both read and verify mode, plus erase, show that the supply flag only matters for programming and that erase restores all ones.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        M_READ,
        M_VERIFY,
        M_PROGRAM,
        M_INHIBIT,
        M_DESELECT,
        M_STANDBY
    } pin_mode_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic vpp;
    } pin_lvls_t;

    function automatic pin_mode_t decode_pins(pin_lvls_t p);
        if (!p.ce_n && !p.oe_n)
            return p.vpp ? M_VERIFY : M_READ;
        else if (p.ce_n)
            return (p.vpp && p.oe_n) ? M_PROGRAM : M_STANDBY;
        else
            return p.vpp ? M_INHIBIT : M_DESELECT;
    endfunction

    function automatic logic drives_bus(pin_mode_t m);
        return (m == M_READ) || (m == M_VERIFY);
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp,
    output pin_mode_t mode,
    output logic      drive
);
    pin_lvls_t lv;

    always_comb begin
        lv.ce_n = ce_n;
        lv.oe_n = oe_n;
        lv.vpp  = vpp;
        mode    = decode_pins(lv);
        drive   = drives_bus(mode);
    end
endmodule

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer
    import eprom_pkg::*;
#(
    parameter int PULSE_MIN = 45,
    parameter int PULSE_MAX = 55
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_t mode_i,
    output logic      commit,
    output logic      err
);
    localparam int CNT_W   = $clog2(PULSE_MAX + 2);
    localparam int CNT_SAT = PULSE_MAX + 1;

    pin_mode_t        prev_q;
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             start;
    logic             bad_width;

    always_comb begin
        start     = (mode_i == M_PROGRAM) && (prev_q == M_INHIBIT);
        commit    = active_q && (mode_i == M_INHIBIT);
        bad_width = (int'(cnt_q) < PULSE_MIN) || (int'(cnt_q) > PULSE_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= M_STANDBY;
            active_q <= 1'b0;
            cnt_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            prev_q   <= mode_i;
            active_q <= start || (active_q && (mode_i == M_PROGRAM));
            if (start)
                cnt_q <= CNT_W'(1);
            else if (active_q && (mode_i == M_PROGRAM) && (int'(cnt_q) < CNT_SAT))
                cnt_q <= cnt_q + CNT_W'(1);
            if (commit && bad_width)
                err_q <= 1'b1;
        end
    end

    assign err = err_q;

    // R5
    commit_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> ($past(mode_i) == M_PROGRAM));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= CNT_SAT);
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    input  logic              wr_en,
    input  logic              drive,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              q_en
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  touched;
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] q_r;
    logic              en_r;

    assign cur = touched[addr] ? cells[addr] : {DATA_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || erase)
            touched <= '0;
        else if (wr_en)
            touched[addr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst && !erase && wr_en)
            cells[addr] <= cur & wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r  <= '0;
            en_r <= 1'b0;
        end else begin
            en_r <= drive;
            q_r  <= drive ? cur : '0;
        end
    end

    assign q    = q_r;
    assign q_en = en_r;

    // R3
    float_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !drive |=> (q == '0));
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
    import eprom_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PULSE_MIN = 45,
    parameter int PULSE_MAX = 55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_pgm_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              q_en,
    output logic              width_err
);
    pin_mode_t mode;
    logic      drive;
    logic      commit;

    eprom_mode_dec u_dec (
        .ce_n  (ce_pgm_n),
        .oe_n  (oe_n),
        .vpp   (vpp_hi),
        .mode  (mode),
        .drive (drive)
    );

    eprom_pulse_timer #(
        .PULSE_MIN (PULSE_MIN),
        .PULSE_MAX (PULSE_MAX)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .commit (commit),
        .err    (width_err)
    );

    eprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .erase (erase),
        .wr_en (commit),
        .drive (drive),
        .addr  (addr),
        .wdata (d),
        .q     (q),
        .q_en  (q_en)
    );

    // R3
    drive_pins_chk: assert property (@(posedge clk) disable iff (rst)
        q_en |-> ($past(!ce_pgm_n) && $past(!oe_n)));
endmodule

// File: tb/eprom_emu_tb.sv
module eprom_emu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_pgm_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        vpp_hi = 1'b0;
    logic        erase = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  d = '0;
    logic [7:0]  q;
    logic        q_en;
    logic        width_err;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [2048];

    always #2.5 clk = ~clk;

    eprom_emu u_dut (
        .clk (clk), .rst (rst), .ce_pgm_n (ce_pgm_n), .oe_n (oe_n),
        .vpp_hi (vpp_hi), .erase (erase), .addr (addr), .d (d),
        .q (q), .q_en (q_en), .width_err (width_err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    endtask

    task automatic read_at(input logic [10:0] a, input logic hv, input string req);
        addr = a; ce_pgm_n = 1'b0; oe_n = 1'b0; vpp_hi = hv;
        @(negedge clk);
        chk(q_en === 1'b1, req, int'(q_en), 1);
        chk(q === model[a], req, int'(q), int'(model[a]));
        oe_n = 1'b1;
    endtask

    // Pulse of width w; abort_kind 0 none, 1 drop supply, 2 drop oe
    task automatic pulse(input logic [10:0] a, input logic [7:0] v, input int w, input int abort_kind);
        addr = a; d = v; vpp_hi = 1'b1; oe_n = 1'b1; ce_pgm_n = 1'b0;
        @(negedge clk);
        ce_pgm_n = 1'b1;
        repeat (w) begin
            @(negedge clk);
            chk(q_en === 1'b0, "R7 no drive in pulse", int'(q_en), 0);
        end
        if (abort_kind == 1) vpp_hi = 1'b0;
        if (abort_kind == 2) oe_n = 1'b0;
        if (abort_kind != 0) @(negedge clk);
        ce_pgm_n = 1'b0; vpp_hi = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        if (abort_kind == 0) model[a] = model[a] & v;
    endtask

    task automatic do_reset();
        rst = 1'b1; ce_pgm_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; erase = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(q_en === 1'b0, "R1 q_en after reset", int'(q_en), 0);
        chk(width_err === 1'b0, "R1 err after reset", int'(width_err), 0);
        read_at(11'h000, 1'b0, "R1 erased low");
        read_at(11'h7FF, 1'b0, "R1 erased high");
    endtask

    task automatic t_program_read();
        pulse(11'h123, 8'hA5, 50, 0);
        chk(width_err === 1'b0, "R8 in-range pulse", int'(width_err), 0);
        read_at(11'h123, 1'b0, "R2 read programmed");
        read_at(11'h123, 1'b1, "R4 verify programmed");
        read_at(11'h124, 1'b1, "R5 neighbour untouched");
        ce_pgm_n = 1'b1; @(negedge clk);
        chk(q_en === 1'b0 && q === 8'h00, "R3 float after read", int'(q), 0);
    endtask

    task automatic t_and_rule();
        pulse(11'h123, 8'hFF, 50, 0);
        read_at(11'h123, 1'b1, "R6 ones over zeros");
        pulse(11'h123, 8'h3C, 50, 0);
        read_at(11'h123, 1'b1, "R5 and with old");
        pulse(11'h123, 8'h3C, 50, 0);
        read_at(11'h123, 1'b1, "R6 repeat pulse");
    endtask

    task automatic t_no_change();
        addr = 11'h200; d = 8'h00;
        vpp_hi = 1'b1; oe_n = 1'b1; ce_pgm_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(q_en === 1'b0, "R7 inhibit float", int'(q_en), 0);
        vpp_hi = 1'b0;
        repeat (4) @(negedge clk);
        chk(q_en === 1'b0, "R7 deselect float", int'(q_en), 0);
        ce_pgm_n = 1'b1; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(q_en === 1'b0 && q === 8'h00, "R7 standby float", int'(q), 0);
        ce_pgm_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        read_at(11'h200, 1'b0, "R7 no write from idle modes");
        pulse(11'h201, 8'h00, 50, 1);
        read_at(11'h201, 1'b1, "R7 abort by supply");
        pulse(11'h202, 8'h00, 50, 2);
        read_at(11'h202, 1'b1, "R7 abort by oe");
    endtask

    task automatic t_width();
        pulse(11'h010, 8'hFE, 45, 0);
        chk(width_err === 1'b0, "R8 width at min", int'(width_err), 0);
        pulse(11'h011, 8'hFD, 55, 0);
        chk(width_err === 1'b0, "R8 width at max", int'(width_err), 0);
        pulse(11'h012, 8'h0F, 44, 0);
        chk(width_err === 1'b1, "R8 width below min", int'(width_err), 1);
        read_at(11'h012, 1'b1, "R8 short pulse applied");
        read_at(11'h010, 1'b0, "R8 min pulse applied");
        repeat (5) @(negedge clk);
        chk(width_err === 1'b1, "R8 sticky", int'(width_err), 1);
        do_reset();
        @(negedge clk);
        chk(width_err === 1'b0, "R8 cleared by reset", int'(width_err), 0);
        pulse(11'h013, 8'hF0, 56, 0);
        chk(width_err === 1'b1, "R8 width above max", int'(width_err), 1);
        read_at(11'h013, 1'b1, "R8 long pulse applied");
    endtask

    task automatic t_erase();
        pulse(11'h055, 8'h00, 50, 0);
        read_at(11'h055, 1'b0, "R9 before erase");
        erase = 1'b1; @(negedge clk); erase = 1'b0;
        model_clear();
        read_at(11'h055, 1'b0, "R9 erased byte");
        read_at(11'h013, 1'b0, "R9 erased other");
        chk(width_err === 1'b1, "R9 err kept", int'(width_err), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_program_read();
        t_and_rule();
        t_no_change();
        t_width();
        t_erase();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule